// File: doc/BRIEF.md
# Four-Slot Non-Blocking Mailbox

This block carries one data word at a time from a producer port to a consumer port. Neither side ever waits for the other. The producer posts a word whenever it likes. The consumer asks for the current word whenever it likes and always gets the newest word that was fully posted. It never gets a torn mix of two words. Words that are overwritten before anyone reads them are lost. There is no queue.

Storage is four data words, addressed by a pair bit and an index bit. Three pieces of shared control state coordinate the two sides:

- a claim bit, owned by the consumer;
- a newest bit, owned by the producer;
- a two-entry index table, one bit per pair, owned by the producer.

Each side runs a short sequencer that makes one access per clock. The producer chooses a pair away from the consumer's claim, chooses the index it did not use last time, stores the word, then publishes the index and the newest pair. The consumer takes the newest pair, claims it, looks up its index and fetches the word. Both sequencers share one clock and may overlap on any cycle. When both touch the same control bit in one cycle, the producer's access is ordered first.

Top module: `quad_slot_mailbox`

## Requirements
- R1: After reset, the claim bit, the newest bit, both index bits and all four words are zero. `rd_data` is zero, both done outputs are low, and a read issued before any write returns zero.
- R2: `wr_start` sampled high while the producer is idle captures `wr_data`. `wr_done` is a single-cycle pulse that goes high 5 rising edges after the edge that sampled the start.
- R3: `rd_start` sampled high while the consumer is idle begins a read. `rd_done` is a single-cycle pulse that goes high 4 rising edges after the edge that sampled the start. `rd_data` carries the fetched word while `rd_done` is high.
- R4: A read started after `wr_done` of a write has been seen, with no write in flight, returns that write's word.
- R5: A read that overlaps writes returns one of two words: the word of the latest write completed before the read started, or the word of a write in flight during the read. It never returns any other value.
- R6: In any cycle where the producer stores and the consumer fetches, their 2-bit slot addresses ({pair, index}) differ.
- R7: Same-cycle control accesses are ordered producer first. A consumer that reads the newest bit in the cycle the producer publishes it takes the new pair, and so returns the new word. A consumer that reads the newest bit one cycle earlier returns the old word.
- R8: The pair value the producer publishes as newest always differs from the claim bit it sampled in its first step.
- R9: Each index-table update by the producer flips the stored bit for that pair.
- R10: A start strobe that arrives while its sequencer is busy is ignored. It causes no extra done pulse and does not alter the word being written.
- R11: `rd_data` changes only in a cycle where `rd_done` is high, and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sequencers |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Producer request strobe |
| wr_data | input | DW | Word to post, captured with the accepted start |
| wr_done | output | 1 | One-cycle pulse when the word is published |
| rd_start | input | 1 | Consumer request strobe |
| rd_data | output | DW | Last fetched word, held between reads |
| rd_done | output | 1 | One-cycle pulse when `rd_data` is fresh |

## Verification
The sharpest corner is a read whose newest-bit lookup falls in exactly the cycle the producer publishes. A design without producer-first forwarding would return the older word there instead of the new one. The same timing shifted one cycle earlier must still give the old word, which catches forwarding applied too eagerly. Long runs of random, overlapping strobes go after torn or stale reads: a wrong pair choice or an index that fails to flip would let the two sides meet on one slot, or hand back a word older than the last completed write. Busy-time strobes target sequencers that restart or recapture data mid-flight.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  localparam int unsigned PAIRS = 2;
  localparam int unsigned SLOTS = 2 * PAIRS;
  localparam int unsigned AW    = $clog2(SLOTS);

  typedef struct packed {
    logic pair;
    logic idx;
  } slot_addr_t;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_PICK_PAIR,
    WS_PICK_IDX,
    WS_STORE,
    WS_PUB_IDX,
    WS_PUB_NEWEST
  } wstate_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_TAKE_NEWEST,
    RS_CLAIM,
    RS_PICK_IDX,
    RS_FETCH
  } rstate_t;
endpackage

// File: rtl/qsm_slots.sv
module qsm_slots import qsm_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [SLOTS];

  // Write port: one word per cycle, cleared on reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) mem[s] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Registered read port; holds its word until the next fetch.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/qsm_ctrl.sv
module qsm_ctrl import qsm_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  // producer side
  input  logic             w_rsample,
  input  logic             w_idx_we,
  input  logic             w_idx_sel,
  input  logic             w_idx_val,
  input  logic             w_new_we,
  input  logic             w_new_val,
  output logic             w_claim,
  output logic [PAIRS-1:0] w_idx,
  // consumer side
  input  logic             r_claim_we,
  input  logic             r_claim_val,
  output logic             r_newest,
  output logic [PAIRS-1:0] r_idx
);
  logic             claim_q;
  logic             newest_q;
  logic [PAIRS-1:0] idx_q;
  logic             seen_claim_q;

  always_ff @(posedge clk) begin
    if (rst)             claim_q <= 1'b0;
    else if (r_claim_we) claim_q <= r_claim_val;
  end

  always_ff @(posedge clk) begin
    if (rst)           newest_q <= 1'b0;
    else if (w_new_we) newest_q <= w_new_val;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic bit_q;
    logic hit;
    assign hit = w_idx_we && (w_idx_sel == 1'(p));
    always_ff @(posedge clk) begin
      if (rst)      bit_q <= 1'b0;
      else if (hit) bit_q <= w_idx_val;
    end
    assign idx_q[p] = bit_q;
    // producer-first: a same-cycle update is visible to the consumer
    assign r_idx[p] = hit ? w_idx_val : bit_q;
  end

  // producer reads before the consumer writes in the same cycle
  assign w_claim  = claim_q;
  assign w_idx    = idx_q;
  assign r_newest = w_new_we ? w_new_val : newest_q;

  // claim value observed by the producer at its first step
  always_ff @(posedge clk) begin
    if (rst)            seen_claim_q <= 1'b0;
    else if (w_rsample) seen_claim_q <= claim_q;
  end

  AST_NEWEST_AWAY: assert property (@(posedge clk) disable iff (rst)
    w_new_we |-> (w_new_val != seen_claim_q)); // R8

  AST_IDX_FLIPS: assert property (@(posedge clk) disable iff (rst)
    w_idx_we |-> (w_idx_val != idx_q[w_idx_sel])); // R9
endmodule

// File: rtl/qsm_writer.sv
module qsm_writer import qsm_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    din,
  input  logic             claim_in,
  input  logic [PAIRS-1:0] idx_in,
  output logic             rsample,
  output logic             st_we,
  output slot_addr_t       st_addr,
  output logic [DW-1:0]    st_data,
  output logic             idx_we,
  output logic             idx_sel,
  output logic             idx_val,
  output logic             new_we,
  output logic             new_val,
  output logic             done
);
  wstate_t       st;
  logic          wp;
  logic          wi;
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WS_IDLE;
      wp     <= 1'b0;
      wi     <= 1'b0;
      word_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        WS_IDLE: if (start) begin
          word_q <= din;
          st     <= WS_PICK_PAIR;
        end
        WS_PICK_PAIR: begin
          wp <= ~claim_in;
          st <= WS_PICK_IDX;
        end
        WS_PICK_IDX: begin
          wi <= ~idx_in[wp];
          st <= WS_STORE;
        end
        WS_STORE:   st <= WS_PUB_IDX;
        WS_PUB_IDX: st <= WS_PUB_NEWEST;
        WS_PUB_NEWEST: begin
          done <= 1'b1;
          st   <= WS_IDLE;
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    rsample = (st == WS_PICK_PAIR);
    st_we   = (st == WS_STORE);
    st_addr = '{pair: wp, idx: wi};
    st_data = word_q;
    idx_we  = (st == WS_PUB_IDX);
    idx_sel = wp;
    idx_val = wi;
    new_we  = (st == WS_PUB_NEWEST);
    new_val = wp;
  end

  AST_WR_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
endmodule

// File: rtl/qsm_reader.sv
module qsm_reader import qsm_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             newest_in,
  input  logic [PAIRS-1:0] idx_in,
  output logic             claim_we,
  output logic             claim_val,
  output logic             fetch_en,
  output slot_addr_t       fetch_addr,
  output logic             done
);
  rstate_t st;
  logic    rp;
  logic    ri;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RS_IDLE;
      rp   <= 1'b0;
      ri   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RS_IDLE: if (start) st <= RS_TAKE_NEWEST;
        RS_TAKE_NEWEST: begin
          rp <= newest_in;
          st <= RS_CLAIM;
        end
        RS_CLAIM: st <= RS_PICK_IDX;
        RS_PICK_IDX: begin
          ri <= idx_in[rp];
          st <= RS_FETCH;
        end
        RS_FETCH: begin
          done <= 1'b1;
          st   <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  always_comb begin
    claim_we   = (st == RS_CLAIM);
    claim_val  = rp;
    fetch_en   = (st == RS_FETCH);
    fetch_addr = '{pair: rp, idx: ri};
  end

  AST_RD_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
endmodule

// File: rtl/quad_slot_mailbox.sv
module quad_slot_mailbox import qsm_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic [DW-1:0] wr_data,
  output logic          wr_done,
  input  logic          rd_start,
  output logic [DW-1:0] rd_data,
  output logic          rd_done
);
  logic             w_rsample, w_st_we, w_idx_we, w_idx_sel, w_idx_val;
  logic             w_new_we, w_new_val;
  slot_addr_t       w_st_addr;
  logic [DW-1:0]    w_st_data;
  logic             r_claim_we, r_claim_val, r_fetch_en;
  slot_addr_t       r_fetch_addr;
  logic             c_claim, c_newest;
  logic [PAIRS-1:0] c_widx, c_ridx;

  qsm_writer #(.DW(DW)) u_writer (
    .clk      (clk),
    .rst      (rst),
    .start    (wr_start),
    .din      (wr_data),
    .claim_in (c_claim),
    .idx_in   (c_widx),
    .rsample  (w_rsample),
    .st_we    (w_st_we),
    .st_addr  (w_st_addr),
    .st_data  (w_st_data),
    .idx_we   (w_idx_we),
    .idx_sel  (w_idx_sel),
    .idx_val  (w_idx_val),
    .new_we   (w_new_we),
    .new_val  (w_new_val),
    .done     (wr_done)
  );

  qsm_reader u_reader (
    .clk        (clk),
    .rst        (rst),
    .start      (rd_start),
    .newest_in  (c_newest),
    .idx_in     (c_ridx),
    .claim_we   (r_claim_we),
    .claim_val  (r_claim_val),
    .fetch_en   (r_fetch_en),
    .fetch_addr (r_fetch_addr),
    .done       (rd_done)
  );

  qsm_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .w_rsample   (w_rsample),
    .w_idx_we    (w_idx_we),
    .w_idx_sel   (w_idx_sel),
    .w_idx_val   (w_idx_val),
    .w_new_we    (w_new_we),
    .w_new_val   (w_new_val),
    .w_claim     (c_claim),
    .w_idx       (c_widx),
    .r_claim_we  (r_claim_we),
    .r_claim_val (r_claim_val),
    .r_newest    (c_newest),
    .r_idx       (c_ridx)
  );

  qsm_slots #(.DW(DW)) u_slots (
    .clk   (clk),
    .rst   (rst),
    .we    (w_st_we),
    .waddr (w_st_addr),
    .wdata (w_st_data),
    .re    (r_fetch_en),
    .raddr (r_fetch_addr),
    .q     (rd_data)
  );

  AST_SLOT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (w_st_we && r_fetch_en) |-> (w_st_addr != r_fetch_addr)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> rd_done); // R11
endmodule

// File: tb/quad_slot_mailbox_tb.sv
module quad_slot_mailbox_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_start = 1'b0;
  logic          rd_start = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_done, rd_done;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  quad_slot_mailbox #(.DW(DW)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .wr_start (wr_start),
    .wr_data  (wr_data),
    .wr_done  (wr_done),
    .rd_start (rd_start),
    .rd_data  (rd_data),
    .rd_done  (rd_done)
  );

  typedef struct packed {
    logic          wr;
    logic [DW-1:0] val;
  } vec_t;

  // writes post val; reads expect val (R1 for the first, R4 otherwise)
  localparam vec_t VEC [12] = '{
    '{1'b0, 32'h0000_0000}, '{1'b1, 32'h1111_0001}, '{1'b0, 32'h1111_0001},
    '{1'b0, 32'h1111_0001}, '{1'b1, 32'h2222_0002}, '{1'b1, 32'h3333_0003},
    '{1'b0, 32'h3333_0003}, '{1'b1, 32'h4444_0004}, '{1'b1, 32'h5555_0005},
    '{1'b1, 32'h6666_0006}, '{1'b0, 32'h6666_0006}, '{1'b0, 32'h6666_0006}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] v, output int lat);
    @(negedge clk); wr_start = 1'b1; wr_data = v;
    @(negedge clk); wr_start = 1'b0; lat = 1;
    while (!wr_done && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic rd_word(output logic [DW-1:0] d, output int lat);
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0; lat = 1;
    while (!rd_done && lat < 20) begin @(negedge clk); lat++; end
    d = rd_data;
  endtask

  // write v, then start a read rd_delay negedges after the write start
  task automatic overlap(input logic [DW-1:0] v, input int rd_delay, output logic [DW-1:0] got);
    int t;
    @(negedge clk); wr_start = 1'b1; wr_data = v;
    for (int i = 1; i <= rd_delay; i++) begin @(negedge clk); wr_start = 1'b0; end
    rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    t = 0;
    while (!rd_done && t < 15) begin @(negedge clk); t++; end
    got = rd_data;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int            lat, cnt, nc;
    logic [DW-1:0] d, held, got, last_done, wcur;
    logic [DW-1:0] cand [4];
    bit            wbusy, rbusy, ok;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, '0);
    check("R1 wr_done after reset", DW'(wr_done), '0);
    check("R1 rd_done after reset", DW'(rd_done), '0);

    // vector table, strictly sequential accesses
    for (int k = 0; k < 12; k++) begin
      if (VEC[k].wr) begin
        wr_word(VEC[k].val, lat);
        check("R2 write latency", DW'(lat), DW'(6));
      end else begin
        rd_word(d, lat);
        check("R1/R4 table read", d, VEC[k].val);
        check("R3 read latency", DW'(lat), DW'(5));
      end
    end

    // R11: output holds across an unrelated write
    rd_word(held, lat);
    wr_word(32'h7777_0007, lat);
    repeat (3) @(negedge clk);
    check("R11 rd_data held", rd_data, held);

    // R10: producer start while busy is ignored
    @(negedge clk); wr_start = 1'b1; wr_data = 32'h8888_0008;
    @(negedge clk); wr_start = 1'b0;
    @(negedge clk); wr_start = 1'b1; wr_data = 32'h9999_0009;
    @(negedge clk); wr_start = 1'b0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (wr_done) cnt++; end
    check("R10 single wr_done", DW'(cnt), DW'(1));
    rd_word(d, lat);
    check("R10 busy write data kept", d, 32'h8888_0008);

    // R10: consumer start while busy is ignored
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (rd_done) cnt++; end
    check("R10 single rd_done", DW'(cnt), DW'(1));

    // R7: producer-first ordering on the newest bit
    wr_word(32'hAAAA_000A, lat);
    rd_word(d, lat);
    check("R4 read after write", d, 32'hAAAA_000A);
    overlap(32'hBBBB_000B, 3, got);
    check("R7 lookup before publish gets old", got, 32'hAAAA_000A);
    rd_word(d, lat);
    check("R4 read after overlap", d, 32'hBBBB_000B);
    overlap(32'hCCCC_000C, 4, got);
    check("R7 lookup with publish gets new", got, 32'hCCCC_000C);

    // random overlapping strobes
    last_done = 32'hCCCC_000C;
    wcur = '0; wbusy = 1'b0; rbusy = 1'b0; nc = 0;
    for (int c = 0; c < 4; c++) cand[c] = '0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (wr_done) begin last_done = wcur; wbusy = 1'b0; end
      if (rd_done) begin
        ok = 1'b0;
        for (int c = 0; c < nc; c++) if (rd_data === cand[c]) ok = 1'b1;
        n_chk++;
        if (!ok) begin
          n_bad++;
          $display("FAIL R5 R6 R8 R9 overlapped read: actual %h expected %h", rd_data, cand[0]);
        end
        rbusy = 1'b0;
      end
      wr_start = 1'b0;
      rd_start = 1'b0;
      if (!wbusy && ($urandom % 3 == 0)) begin
        wcur = DW'($urandom);
        wr_data = wcur; wr_start = 1'b1; wbusy = 1'b1;
        if (rbusy && nc < 4) begin cand[nc] = wcur; nc++; end
      end
      if (!rbusy && ($urandom % 3 == 0)) begin
        rd_start = 1'b1; rbusy = 1'b1;
        cand[0] = last_done; nc = 1;
        if (wbusy) begin cand[1] = wcur; nc = 2; end
      end
    end
    wr_start = 1'b0;
    rd_start = 1'b0;
    repeat (10) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule